// File: doc/BRIEF.md
# Jack-Detect Output Switch Controller

This block chooses, from a jack-detect signal, which of two audio output stages may be enabled: a headphone stage or a speaker stage. One of three candidate detect pins is selected: the general-purpose pin GPIO1, the left jack-detect pin or the right jack-detect pin. The chosen pin is brought into the clock domain through a synchroniser. It is then filtered by a tick-driven debouncer whose period is either fast or slow. The debounced level, with a programmable polarity, decides which output stage is forced off. The other stage follows its own enable bit from the control registers.

When switching is disabled, both register enable bits pass straight through, and the detect level has no effect. A third output enable follows the final headphone enable when capless operation is selected, so the three stages switch together. The debounced level can also be driven out on GPIO1, unless GPIO1 is in use as an input. It is also not driven while GPIO1 carries the ADC frame clock.

Top module: `jd_out_switch`

## Requirements
- R1: With `sw_en`=0, `hp_en` equals `hp_reg` and `spk_en` equals `spk_reg`, whatever the detect level and `sw_pol`.
- R2: With `sw_en`=1 and `sw_pol`=0, a debounced level of 0 gives `hp_en`=0 and `spk_en`=`spk_reg`. A level of 1 gives `spk_en`=0 and `hp_en`=`hp_reg`.
- R3: With `sw_en`=1 and `sw_pol`=1, a debounced level of 0 gives `spk_en`=0 and `hp_en`=`hp_reg`. A level of 1 gives `hp_en`=0 and `spk_en`=`spk_reg`.
- R4: `src_sel` picks the detect pin: 00 selects `pin_gpio1`, 01 selects `pin_jd_left`, and 10 or 11 select `pin_jd_right`. With 00 selected and `gpio1_free`=0, the detect input reads as 0.
- R5: The selected pin passes through two flops before the debouncer. With ticks on every cycle in fast mode, a pin change made before edge 1 leaves the level unchanged after edge 5.
- R6: The debounced level takes the synchronised value on the Nth tick at which that value has differed from it. N is 4 with `dbnc_slow`=0 and 64 with `dbnc_slow`=1. Any cycle at which the synchronised value equals the level restarts the count. In the R5 case the level changes after edge 6.
- R7: While `dbnc_run`=0 the debounced level holds and the count is cleared.
- R8: `cap_en` equals `hp_en` when `capless_en`=1 and is 0 otherwise.
- R9: `gpio1_oe` is `gpio_det_req` AND `gpio1_free` AND NOT `gpio1_is_input`. `gpio1_drv` is the debounced level while `gpio1_oe`=1 and 0 otherwise.
- R10: During and right after reset the debounced level is 0, and every enable is already the value computed from a level of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en | input | 1 | Detect-driven switching enable |
| sw_pol | input | 1 | Detect polarity |
| src_sel | input | 2 | Detect pin select |
| dbnc_run | input | 1 | Debounce timer enable |
| dbnc_slow | input | 1 | 1 = slow debounce (64 ticks), 0 = fast (4 ticks) |
| tick | input | 1 | Debounce tick enable |
| capless_en | input | 1 | Capless mode: third output follows headphone |
| hp_reg | input | 1 | Headphone enable register bit |
| spk_reg | input | 1 | Speaker enable register bit |
| gpio1_free | input | 1 | GPIO1 released from the ADC frame-clock role |
| gpio1_is_input | input | 1 | GPIO1 configured as an input |
| gpio_det_req | input | 1 | Request to drive the debounced level onto GPIO1 |
| pin_gpio1 | input | 1 | Raw GPIO1 pin |
| pin_jd_left | input | 1 | Raw left jack-detect pin |
| pin_jd_right | input | 1 | Raw right jack-detect pin |
| hp_en | output | 1 | Final headphone enable |
| spk_en | output | 1 | Final speaker enable |
| cap_en | output | 1 | Capless companion output enable |
| gpio1_oe | output | 1 | GPIO1 output enable |
| gpio1_drv | output | 1 | GPIO1 output value |

## Verification
The hardest case to reach from the ports is a debounce count that almost completes and is then restarted. In that case the level must survive a pulse of exactly N-1 ticks. The stimulus holds the tick high on every cycle in fast mode and pulses the left pin for three cycles. It then waits well past the window and checks that the level did not move. The same tick-every-cycle setup fixes the cycle at which a clean edge appears, which separates the synchroniser depth from the tick count. A long random phase with rare pin flips, sparse ticks and reconfiguration between modes covers the cases where the count is left part-way through a mode change.

// File: rtl/jd_pkg.sv
`timescale 1ns/1ps
package jd_pkg;
  typedef enum logic [1:0] {
    SRC_GPIO1     = 2'b00,
    SRC_JD_LEFT   = 2'b01,
    SRC_JD_RIGHT  = 2'b10,
    SRC_JD_RIGHT2 = 2'b11
  } jd_src_e;

  typedef struct packed {
    logic hp;
    logic spk;
    logic cap;
  } out_en_t;
endpackage

// File: rtl/jd_src_sync.sv
`timescale 1ns/1ps
module jd_src_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       gpio1_free,
  input  logic       pin_gpio1,
  input  logic       pin_left,
  input  logic       pin_right,
  output logic       det_sync
);
  import jd_pkg::*;

  logic                   raw_sel;
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  // R4: source choice; GPIO1 only counts when freed from frame-clock duty
  always_comb begin
    case (src_sel)
      SRC_GPIO1:   raw_sel = pin_gpio1 & gpio1_free;
      SRC_JD_LEFT: raw_sel = pin_left;
      default:     raw_sel = pin_right;
    endcase
  end

  // R5: shift chain
  always_comb chain_d = {chain_q[SYNC_STAGES-2:0], raw_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign det_sync = chain_q[SYNC_STAGES-1];

  // R5: output only ever takes a value the selected input had earlier
  p_sync_no_shortcut_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det_sync != $past(det_sync)) |-> ($past(chain_q[SYNC_STAGES-2]) == det_sync));
endmodule

// File: rtl/jd_debounce.sv
`timescale 1ns/1ps
module jd_debounce #(
  parameter int FAST_TICKS = 4,
  parameter int SLOW_TICKS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  input  logic tick,
  input  logic det_in,
  output logic level
);
  localparam int CW = $clog2(SLOW_TICKS + 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_TICKS - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic [CW-1:0] limit;

  assign limit = slow ? SLOW_LIM : FAST_LIM;

  // R6, R7: next-state
  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (!run) begin
      cnt_d = '0;
    end else if (det_in == lvl_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= limit) begin
        lvl_d = det_in;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  // R10: level resets to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;

  p_hold_without_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(lvl_q));
  p_new_level_from_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(det_in) == lvl_q));
  p_count_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_in == lvl_q) |=> (cnt_q == '0));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(SLOW_TICKS));
  p_frozen_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(lvl_q) && cnt_q == '0));
endmodule

// File: rtl/jd_enable_map.sv
`timescale 1ns/1ps
module jd_enable_map (
  input  logic            sw_en,
  input  logic            sw_pol,
  input  logic            level,
  input  logic            hp_reg,
  input  logic            spk_reg,
  input  logic            capless_en,
  output jd_pkg::out_en_t en
);
  logic hp_kill;
  logic spk_kill;

  // R2/R3: level equal to polarity means "no headphone"
  assign hp_kill  = sw_en & (level == sw_pol);
  assign spk_kill = sw_en & (level != sw_pol);

  always_comb begin
    en.hp  = hp_reg  & ~hp_kill;
    en.spk = spk_reg & ~spk_kill;
    en.cap = capless_en & en.hp;   // R8
  end
endmodule

// File: rtl/jd_out_switch.sv
`timescale 1ns/1ps
module jd_out_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int FAST_TICKS  = 4,
  parameter int SLOW_TICKS  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_en,
  input  logic       sw_pol,
  input  logic [1:0] src_sel,
  input  logic       dbnc_run,
  input  logic       dbnc_slow,
  input  logic       tick,
  input  logic       capless_en,
  input  logic       hp_reg,
  input  logic       spk_reg,
  input  logic       gpio1_free,
  input  logic       gpio1_is_input,
  input  logic       gpio_det_req,
  input  logic       pin_gpio1,
  input  logic       pin_jd_left,
  input  logic       pin_jd_right,
  output logic       hp_en,
  output logic       spk_en,
  output logic       cap_en,
  output logic       gpio1_oe,
  output logic       gpio1_drv
);
  import jd_pkg::*;

  logic    det_sync;
  logic    det_level;
  out_en_t en;

  jd_src_sync #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .gpio1_free (gpio1_free),
    .pin_gpio1  (pin_gpio1),
    .pin_left   (pin_jd_left),
    .pin_right  (pin_jd_right),
    .det_sync   (det_sync)
  );

  jd_debounce #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_dbnc (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (dbnc_run),
    .slow   (dbnc_slow),
    .tick   (tick),
    .det_in (det_sync),
    .level  (det_level)
  );

  jd_enable_map u_map (
    .sw_en      (sw_en),
    .sw_pol     (sw_pol),
    .level      (det_level),
    .hp_reg     (hp_reg),
    .spk_reg    (spk_reg),
    .capless_en (capless_en),
    .en         (en)
  );

  assign hp_en  = en.hp;
  assign spk_en = en.spk;
  assign cap_en = en.cap;

  // R9: GPIO1 drive
  assign gpio1_oe  = gpio_det_req & gpio1_free & ~gpio1_is_input;
  assign gpio1_drv = gpio1_oe & det_level;

  p_passthrough_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |-> (hp_en == hp_reg && spk_en == spk_reg));
  p_never_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !(hp_en && spk_en));
  p_one_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && hp_reg && spk_reg) |-> (hp_en != spk_en));
  p_cap_tracks_hp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |-> (hp_en && capless_en));
  p_gpio_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio1_is_input || !gpio1_free) |-> (!gpio1_oe && !gpio1_drv));
endmodule

// File: tb/tb_jd_out_switch.sv
`timescale 1ns/1ps
module tb_jd_out_switch;
  logic clk, rst_n;
  logic sw_en, sw_pol, dbnc_run, dbnc_slow, tick, capless_en, hp_reg, spk_reg;
  logic gpio1_free, gpio1_is_input, gpio_det_req, pin_gpio1, pin_jd_left, pin_jd_right;
  logic [1:0] src_sel;
  logic hp_en, spk_en, cap_en, gpio1_oe, gpio1_drv;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  jd_out_switch dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Behavioural reference: pipeline of two samples, tick counter, level
  int m_s1, m_s2, m_cnt, m_lvl;
  always @(posedge clk or negedge rst_n) begin
    int raw, lim;
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_cnt <= 0; m_lvl <= 0;
    end else begin
      if (src_sel == 2'd0)      raw = (pin_gpio1 && gpio1_free) ? 1 : 0;
      else if (src_sel == 2'd1) raw = pin_jd_left;
      else                      raw = pin_jd_right;
      lim = dbnc_slow ? 64 : 4;
      m_s1 <= raw;
      m_s2 <= m_s1;
      if (!dbnc_run || m_s2 == m_lvl) m_cnt <= 0;
      else if (tick) begin
        if (m_cnt + 1 >= lim) begin m_lvl <= m_s2; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always begin
    int eh, es, eoe;
    string tag;
    @(posedge clk); #2;
    if (rst_n && !done) begin
      if (!sw_en) begin eh = hp_reg; es = spk_reg; tag = "R1"; end
      else begin
        tag = sw_pol ? "R3" : "R2";
        if (m_lvl == int'(sw_pol)) begin eh = 0; es = spk_reg; end
        else begin eh = hp_reg; es = 0; end
      end
      chk({tag, " hp_en"}, hp_en, eh);
      chk({tag, " spk_en"}, spk_en, es);
      chk("R8 cap_en", cap_en, capless_en ? eh : 0);
      eoe = (gpio_det_req && gpio1_free && !gpio1_is_input) ? 1 : 0;
      chk("R9 gpio1_oe", gpio1_oe, eoe);
      chk("R9 gpio1_drv", gpio1_drv, eoe ? m_lvl : 0);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    sw_en = 1; sw_pol = 0; src_sel = 2'b01; dbnc_run = 1; dbnc_slow = 0; tick = 1;
    capless_en = 1; hp_reg = 1; spk_reg = 1; gpio1_free = 1; gpio1_is_input = 0;
    gpio_det_req = 1; pin_gpio1 = 0; pin_jd_left = 0; pin_jd_right = 0;
    wait_cyc(3);
    // R10: level 0 in reset, enables already derived from it
    chk("R10 hp_en in reset", hp_en, 0);
    chk("R10 spk_en in reset", spk_en, 1);
    chk("R10 gpio1_drv in reset", gpio1_drv, 0);
    @(negedge clk) rst_n = 1;
    wait_cyc(1);
    chk("R10 spk_en after reset", spk_en, 1);

    // R5/R6: exact edge of a clean change
    @(negedge clk) pin_jd_left = 1;
    wait_cyc(5);
    chk("R5 level after edge 5", gpio1_drv, 0);
    wait_cyc(1);
    chk("R6 level after edge 6", gpio1_drv, 1);
    chk("R2 hp passed at level 1", hp_en, 1);
    chk("R2 spk off at level 1", spk_en, 0);

    // R6: three-tick pulse must not flip the level
    @(negedge clk) pin_jd_left = 0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk) pin_jd_left = 1;
    wait_cyc(12);
    chk("R6 short pulse rejected", gpio1_drv, 1);

    // R7: debouncer stopped
    @(negedge clk) begin dbnc_run = 0; pin_jd_left = 0; end
    wait_cyc(20);
    chk("R7 level frozen", gpio1_drv, 1);
    @(negedge clk) dbnc_run = 1;
    wait_cyc(10);
    chk("R7 level moves after restart", gpio1_drv, 0);

    // R6: slow period
    @(negedge clk) begin dbnc_slow = 1; pin_jd_left = 1; end
    wait_cyc(40);
    chk("R6 slow not yet", gpio1_drv, 0);
    wait_cyc(40);
    chk("R6 slow settled", gpio1_drv, 1);
    @(negedge clk) dbnc_slow = 0;

    // R4: source encoding
    @(negedge clk) begin src_sel = 2'b11; pin_jd_right = 0; end
    wait_cyc(10);
    chk("R4 sel 11 uses right pin", gpio1_drv, 0);
    @(negedge clk) begin src_sel = 2'b10; pin_jd_right = 1; pin_jd_left = 0; end
    wait_cyc(10);
    chk("R4 sel 10 uses right pin", gpio1_drv, 1);
    @(negedge clk) begin src_sel = 2'b00; gpio1_free = 0; pin_gpio1 = 1; end
    wait_cyc(10);
    chk("R4 GPIO1 source blocked reads 0", hp_en, 0);
    @(negedge clk) gpio1_free = 1;
    wait_cyc(10);
    chk("R4 GPIO1 source when free", gpio1_drv, 1);
    @(negedge clk) begin src_sel = 2'b01; pin_jd_left = 0; end
    wait_cyc(10);
    chk("R4 sel 01 uses left pin", gpio1_drv, 0);

    // R1, R3, R8, R9 directed
    @(negedge clk) sw_en = 0;
    wait_cyc(1);
    chk("R1 passthrough hp", hp_en, 1);
    chk("R1 passthrough spk", spk_en, 1);
    @(negedge clk) begin sw_en = 1; sw_pol = 1; end
    wait_cyc(1);
    chk("R3 level 0 passes hp", hp_en, 1);
    chk("R3 level 0 kills spk", spk_en, 0);
    @(negedge clk) capless_en = 0;
    wait_cyc(1);
    chk("R8 cap off without capless", cap_en, 0);
    @(negedge clk) capless_en = 1;
    wait_cyc(1);
    chk("R8 cap follows hp", cap_en, 1);
    @(negedge clk) begin gpio1_is_input = 1; pin_jd_left = 1; end
    wait_cyc(10);
    chk("R9 no drive when GPIO1 is input", gpio1_oe, 0);
    @(negedge clk) gpio1_is_input = 0;
    wait_cyc(1);
    chk("R9 drive restored", gpio1_drv, 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 15) == 0) pin_jd_left  = ~pin_jd_left;
      if ($urandom_range(0, 15) == 0) pin_jd_right = ~pin_jd_right;
      if ($urandom_range(0, 15) == 0) pin_gpio1    = ~pin_gpio1;
      if ($urandom_range(0, 7) == 0) begin
        sw_en = 1'($urandom); sw_pol = 1'($urandom); hp_reg = 1'($urandom);
        spk_reg = 1'($urandom); capless_en = 1'($urandom);
        gpio_det_req = 1'($urandom); gpio1_is_input = ($urandom_range(0, 3) == 0);
        gpio1_free = ($urandom_range(0, 3) != 0);
      end
      if ($urandom_range(0, 199) == 0) src_sel = 2'($urandom);
      if ($urandom_range(0, 299) == 0) dbnc_slow = ~dbnc_slow;
      if ($urandom_range(0, 99) == 0) dbnc_run = ~dbnc_run;
    end
    wait_cyc(2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule